// File: doc/BRIEF.md
# Solenoid Driver Fault Monitor

This block watches a set of solenoid-valve driver channels in a braking controller. Each channel has three inputs: the command sent to the high-side driver, the level the driver actually puts out, and the driver's active-low health flag. The block raises a driver fault when command and output disagree, and a valve fault when the health flag drops. A disagreement is not counted during a settling window after each command change. Either condition must also hold for a set number of back-to-back clock cycles before it counts.

The first accepted fault sets two latched outputs. One lights the warning lamp and the other disables anti-lock control. The block also places a fault code on its outputs and raises an interrupt, and it holds both until the host acknowledges. When several faults arrive, the lowest-numbered one is reported first. The others wait in a pending mask and are presented one at a time, each after the previous acknowledge.

Top module: `valve_fault_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `irq_o`, `inhibit_o` and `lamp_o` are 0 and `code_o` is all zeros.
- R2: A confirmed command/output disagreement on channel n produces `code_o` = {n, 2'b01}. The channel index is in the upper bits and the type is in the two lowest bits. Counting from the first clock edge at which the disagreement is seen with no settle window open, the code and interrupt appear right after the CONFIRM_CYC-th edge.
- R3: A disagreement is ignored at the edge where a channel's command changes and at the SETTLE_CYC edges after it. An output that never follows a command is therefore reported only after SETTLE_CYC+CONFIRM_CYC+1 edges.
- R4: A disagreement or a low health flag that lasts fewer than CONFIRM_CYC consecutive edges is discarded, and the count starts again from zero.
- R5: A health flag held low for CONFIRM_CYC consecutive edges on channel n produces `code_o` = {n, 2'b10}. No settle window applies to this flag.
- R6: `inhibit_o` and `lamp_o` go high together with the first interrupt and stay high until reset, whatever the host does.
- R7: `irq_o` and `code_o` hold steady while no acknowledge arrives. An `ack_i` sampled high while `irq_o` is high clears `irq_o` after that edge. An `ack_i` sampled while `irq_o` is low changes nothing.
- R8: Faults confirmed in the same cycle are reported lowest channel first. After each acknowledge, `irq_o` stays low for exactly one cycle and then rises again with the next pending code.
- R9: Within one channel, a driver fault is reported before a valve fault. Each channel and type pair is reported at most once until reset, even if the condition persists.
- R10: When each output matches its command (both 0 or both 1), or follows a change within the settle window, and every health flag is high, no fault is ever raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | NUM_CH | Command to each valve driver |
| drv_out_i | input | NUM_CH | Output level reported by each driver |
| stat_n_i | input | NUM_CH | Driver health flag, low on open or short |
| ack_i | input | 1 | Host acknowledge of the current code |
| irq_o | output | 1 | Interrupt: a fault code is waiting |
| code_o | output | $clog2(NUM_CH)+2 | Channel index (upper bits) and fault type (low two bits) |
| inhibit_o | output | 1 | Latched disable of anti-lock control |
| lamp_o | output | 1 | Latched fault lamp drive |

## Verification
The hardest case to reach is several faults confirmed on the same edge, including both fault types on one channel. To set it up, the bench first raises the command of channel 0 together with its output and waits out the settle window. Then, on a single negative edge, it drops that output and pulls two health flags low, so that three conditions reach their confirmation count together. The bench then walks through the queue with acknowledges. It checks the one-cycle gap between codes, the order of the codes, and that the conditions, which are still present, raise no further interrupt.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  typedef enum logic [1:0] {
    FT_NONE = 2'b00,
    FT_DRV  = 2'b01,
    FT_VLV  = 2'b10
  } fault_t;
endpackage

// File: rtl/vfm_chan.sv
// One channel: settle blanking, persistence counters and one-shot fault hits.
module vfm_chan #(
  parameter int SETTLE_CYC  = 8,
  parameter int CONFIRM_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_i,
  input  logic drv_i,
  input  logic stat_n_i,
  output logic hit_drv_o,
  output logic hit_vlv_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int CW = $clog2(CONFIRM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CONFIRM_CYC - 1);

  logic          cmd_q;
  logic [SW-1:0] settle_cnt;
  logic [CW-1:0] mm_cnt, vl_cnt;
  logic          done_drv, done_vlv;
  logic          chg, blank, mm_now, vl_now;

  assign chg    = cmd_i ^ cmd_q;
  assign blank  = chg | (settle_cnt != '0);
  assign mm_now = (cmd_i ^ drv_i) & ~blank;
  assign vl_now = ~stat_n_i;

  assign hit_drv_o = mm_now & (mm_cnt == LAST) & ~done_drv;
  assign hit_vlv_o = vl_now & (vl_cnt == LAST) & ~done_vlv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= 1'b0;
      settle_cnt <= '0;
      mm_cnt     <= '0;
      vl_cnt     <= '0;
      done_drv   <= 1'b0;
      done_vlv   <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      if (chg)
        settle_cnt <= SW'(SETTLE_CYC);
      else if (settle_cnt != '0)
        settle_cnt <= settle_cnt - SW'(1);
      if (!mm_now)
        mm_cnt <= '0;
      else if (mm_cnt != LAST)
        mm_cnt <= mm_cnt + CW'(1);
      if (!vl_now)
        vl_cnt <= '0;
      else if (vl_cnt != LAST)
        vl_cnt <= vl_cnt + CW'(1);
      done_drv <= done_drv | hit_drv_o;
      done_vlv <= done_vlv | hit_vlv_o;
    end
  end

  generate
    if (CONFIRM_CYC > 1) begin : g_chk
      assert_drv_persist_R4: assert property (@(posedge clk) disable iff (rst)
        hit_drv_o |-> $past(cmd_i != drv_i));
      assert_cmd_steady_R3: assert property (@(posedge clk) disable iff (rst)
        hit_drv_o |-> ($past(cmd_i) == cmd_i));
      assert_vlv_persist_R5: assert property (@(posedge clk) disable iff (rst)
        hit_vlv_o |-> $past(!stat_n_i));
    end
  endgenerate
endmodule

// File: rtl/vfm_prio.sv
// Lowest-index-first priority pick.
module vfm_prio #(
  parameter int W = 8
) (
  input  logic [W-1:0]         req_i,
  output logic [W-1:0]         gnt_o,
  output logic [$clog2(W)-1:0] idx_o,
  output logic                 any_o
);
  localparam int IW = $clog2(W);

  logic found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        found    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vfm_report.sv
// Latches lamp/inhibit, queues faults and presents one code per interrupt.
module vfm_report
  import vfm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         hit_drv_i,
  input  logic [NUM_CH-1:0]         hit_vlv_i,
  input  logic                      ack_i,
  output logic                      irq_o,
  output logic [$clog2(NUM_CH)+1:0] code_o,
  output logic                      inhibit_o,
  output logic                      lamp_o
);
  localparam int W      = 2 * NUM_CH;
  localparam int IW     = $clog2(W);
  localparam int CODE_W = $clog2(NUM_CH) + 2;

  logic [W-1:0]      hits, pend_q, req, gnt;
  logic [IW-1:0]     idx;
  logic              any, load;
  fault_t            ft;
  logic [CODE_W-1:0] code_q;
  logic              irq_q, inhibit_q, lamp_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      assign hits[2*c]   = hit_drv_i[c];
      assign hits[2*c+1] = hit_vlv_i[c];
    end
  endgenerate

  assign req = pend_q | hits;

  vfm_prio #(.W(W)) u_prio (
    .req_i (req),
    .gnt_o (gnt),
    .idx_o (idx),
    .any_o (any)
  );

  assign load = !irq_q && any;
  assign ft   = idx[0] ? FT_VLV : FT_DRV;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      code_q    <= '0;
      irq_q     <= 1'b0;
      inhibit_q <= 1'b0;
      lamp_q    <= 1'b0;
    end else begin
      inhibit_q <= inhibit_q | (|hits);
      lamp_q    <= lamp_q | (|hits);
      pend_q    <= load ? (req & ~gnt) : req;
      if (irq_q && ack_i)
        irq_q <= 1'b0;
      else if (load)
        irq_q <= 1'b1;
      if (load)
        code_q <= {idx[IW-1:1], ft};
    end
  end

  assign irq_o     = irq_q;
  assign code_o    = code_q;
  assign inhibit_o = inhibit_q;
  assign lamp_o    = lamp_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> (irq_o && $stable(code_o)));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    inhibit_o |=> (inhibit_o && lamp_o));
  assert_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> inhibit_o);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

// File: rtl/valve_fault_monitor.sv
module valve_fault_monitor #(
  parameter int NUM_CH      = 4,
  parameter int SETTLE_CYC  = 8,
  parameter int CONFIRM_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         cmd_i,
  input  logic [NUM_CH-1:0]         drv_out_i,
  input  logic [NUM_CH-1:0]         stat_n_i,
  input  logic                      ack_i,
  output logic                      irq_o,
  output logic [$clog2(NUM_CH)+1:0] code_o,
  output logic                      inhibit_o,
  output logic                      lamp_o
);
  logic [NUM_CH-1:0] hit_drv, hit_vlv;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      vfm_chan #(
        .SETTLE_CYC  (SETTLE_CYC),
        .CONFIRM_CYC (CONFIRM_CYC)
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd_i[c]),
        .drv_i     (drv_out_i[c]),
        .stat_n_i  (stat_n_i[c]),
        .hit_drv_o (hit_drv[c]),
        .hit_vlv_o (hit_vlv[c])
      );
    end
  endgenerate

  vfm_report #(.NUM_CH(NUM_CH)) u_report (
    .clk       (clk),
    .rst       (rst),
    .hit_drv_i (hit_drv),
    .hit_vlv_i (hit_vlv),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .code_o    (code_o),
    .inhibit_o (inhibit_o),
    .lamp_o    (lamp_o)
  );
endmodule

// File: tb/valve_fault_monitor_tb.sv
module valve_fault_monitor_tb;
  localparam int N = 4;
  localparam int S = 8;
  localparam int C = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] cmd = '0, drv = '0, stat_n = '1;
  logic         ack = 1'b0;
  logic         irq, inhibit, lamp;
  logic [3:0]   code;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  valve_fault_monitor #(.NUM_CH(N), .SETTLE_CYC(S), .CONFIRM_CYC(C)) u_dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .drv_out_i(drv), .stat_n_i(stat_n),
    .ack_i(ack), .irq_o(irq), .code_o(code), .inhibit_o(inhibit), .lamp_o(lamp)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd = '0; drv = '0; stat_n = '1; ack = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; stat_n = '0;
    step(3);
    chk("R1 irq in reset", irq, 0);
    chk("R1 outputs in reset", {inhibit, lamp, code}, 0);
    stat_n = '1; rst = 1'b0;
    step(1);
    chk("R1 outputs after release", {irq, inhibit, lamp, code}, 0);
  endtask

  task automatic t_normal();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      cmd = cmd ^ 4'(i + 5); drv = cmd;
      step(3);
    end
    cmd[3] = ~cmd[3];
    step(S - 2);
    drv[3] = cmd[3];
    step(2 * C + 2);
    chk("R10 no fault in normal run", {irq, inhibit, lamp}, 0);
  endtask

  task automatic t_settle();
    do_reset();
    cmd[2] = 1'b1;
    step(S + C);
    chk("R3 no fault inside settle+confirm", {irq, inhibit}, 0);
    step(1);
    chk("R2 irq after confirm", irq, 1);
    chk("R2 code ch2 mismatch", code, 4'h9);
    chk("R6 lamp and inhibit set", {inhibit, lamp}, 2'b11);
  endtask

  task automatic t_glitch();
    do_reset();
    cmd[1] = 1'b1; drv[1] = 1'b1;
    step(S + 2);
    drv[1] = 1'b0;
    step(C - 1);
    drv[1] = 1'b1;
    step(2 * C);
    chk("R4 short mismatch discarded", {irq, inhibit}, 0);
    drv[1] = 1'b0;
    step(C - 1);
    chk("R4 not yet confirmed", irq, 0);
    step(1);
    chk("R2 code ch1 mismatch", {irq, code}, 5'h15);
  endtask

  task automatic t_valve_ack();
    do_reset();
    stat_n[3] = 1'b0;
    step(C - 1);
    chk("R5 not yet confirmed", irq, 0);
    step(1);
    chk("R5 code ch3 valve", {irq, code}, 5'h1E);
    step(5);
    chk("R7 irq and code held", {irq, code}, 5'h1E);
    ack_pulse();
    chk("R7 ack clears irq", irq, 0);
    step(3);
    chk("R7 code kept after ack", code, 4'hE);
    chk("R6 latched after ack", {inhibit, lamp}, 2'b11);
    ack_pulse();
    step(2);
    chk("R7 idle ack ignored", {irq, code}, 5'h0E);
    chk("R9 persistent flag not re-reported", irq, 0);
  endtask

  task automatic t_multi();
    do_reset();
    cmd[0] = 1'b1; drv[0] = 1'b1;
    step(S + 2);
    drv[0] = 1'b0; stat_n[0] = 1'b0; stat_n[2] = 1'b0;
    step(C);
    chk("R8 first code ch0 mismatch", {irq, code}, 5'h11);
    step(2);
    chk("R8 first code held", {irq, code}, 5'h11);
    ack_pulse();
    chk("R8 gap after ack", irq, 0);
    step(1);
    chk("R9 ch0 valve after mismatch", {irq, code}, 5'h12);
    ack_pulse();
    chk("R8 gap after second ack", irq, 0);
    step(1);
    chk("R8 ch2 valve last", {irq, code}, 5'h1A);
    ack_pulse();
    step(2 * C);
    chk("R9 each fault reported once", irq, 0);
    chk("R6 still latched", {inhibit, lamp}, 2'b11);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_settle();
    t_glitch();
    t_valve_ack();
    t_multi();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule